// File: doc/BRIEF.md
# DMA Translation Fault Capture

This block sits beside an address translation unit and keeps a record of the first DMA access that failed to translate. The translation unit presents a one-cycle fault event that says whether the failure was a missing segment or a missing page, which page address was touched, whether the access was a read or a write, and which requester issued it. When the fault class is enabled and no earlier fault is pending, the block latches these fields into a 64-bit status register, sets a valid flag and raises a level interrupt.

Software reaches the block over a minimal register bus with two 64-bit registers: the status record and a class-enable mask. The interrupt handler reads the status, logs it, then writes the record back with the valid flag cleared, which drops the interrupt and re-arms capture. Faults that arrive while a record is pending are discarded, so the record always describes the oldest unacknowledged fault.

Top module: `fault_cap_top`

## Requirements
- R1: After a synchronous reset the status register reads 0, the mask register reads 0 and `irq_o` is low.
- R2: An enabled fault presented while no record is pending is latched by the next clock edge: status bit 63 = 1, bit 62 = 1 for a segment fault (`flt_kind_i` = 0) or bit 61 = 1 for a page fault (`flt_kind_i` = 1), bits 34:12 = page address, bit 11 = direction (1 read, 0 write), bits 10:0 = requester ID.
- R3: `irq_o` equals status bit 63; it goes high in the first cycle after an enabled fault is presented.
- R4: While status bit 63 is set, further fault events are dropped and every status field stays unchanged.
- R5: Mask bit 62 enables segment faults and mask bit 61 enables page faults; a fault of a disabled class is neither recorded nor signalled.
- R6: A mask write stores bits 62 and 61; a mask read returns those two bits and 0 in every other position, and the mask changes only on a mask write.
- R7: A status write loads the record from the written data; writing bit 63 as 0 clears the record's valid flag and `irq_o` is low from the next cycle.
- R8: When a status write and a fault event fall in the same cycle, the write takes effect and the fault is dropped.
- R9: Status bits 60:35 are not stored and always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data of the selected register (combinational) |
| flt_valid_i | input | 1 | Fault event present this cycle |
| flt_kind_i | input | 1 | Fault class: 0 segment, 1 page |
| flt_page_i | input | 23 | Faulting page address |
| flt_read_i | input | 1 | Access direction: 1 read, 0 write |
| flt_rid_i | input | 11 | Requester ID of the faulting access |
| irq_o | output | 1 | Level interrupt, high while a record is pending |

## Verification
The properties assume that the fault inputs are meaningful only in cycles where `flt_valid_i` is high and that a register write strobe lasts exactly one cycle with stable address and data. The stimulus drives every input on the falling clock edge, pulses each fault and each write for a single cycle, and returns `flt_valid_i` and `reg_wr_i` to 0 between operations. Same-cycle write and fault collisions are created deliberately only for the priority check, so the remaining properties see one event at a time.

// File: rtl/fault_cap_pkg.sv
package fault_cap_pkg;

    localparam int DATA_W    = 64;
    localparam int PAGE_W    = 23;
    localparam int RID_W     = 11;

    localparam int VALID_BIT = DATA_W - 1;
    localparam int SEG_BIT   = DATA_W - 2;
    localparam int PG_BIT    = DATA_W - 3;
    localparam int DIR_BIT   = RID_W;
    localparam int PAGE_LSB  = RID_W + 1;
    localparam int PAGE_MSB  = PAGE_LSB + PAGE_W - 1;

    typedef enum logic {
        KIND_SEG  = 1'b0,
        KIND_PAGE = 1'b1
    } fault_kind_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              seg;
        logic              pg;
        logic [PAGE_W-1:0] page;
        logic              rd;
        logic [RID_W-1:0]  rid;
    } fault_rec_t;

    typedef struct packed {
        logic seg_en;
        logic pg_en;
    } class_en_t;

    function automatic logic [DATA_W-1:0] rec_to_word(fault_rec_t r);
        logic [DATA_W-1:0] w;
        w                    = '0;
        w[VALID_BIT]         = r.valid;
        w[SEG_BIT]           = r.seg;
        w[PG_BIT]            = r.pg;
        w[PAGE_MSB:PAGE_LSB] = r.page;
        w[DIR_BIT]           = r.rd;
        w[RID_W-1:0]         = r.rid;
        return w;
    endfunction

    function automatic fault_rec_t word_to_rec(logic [DATA_W-1:0] w);
        fault_rec_t r;
        r.valid = w[VALID_BIT];
        r.seg   = w[SEG_BIT];
        r.pg    = w[PG_BIT];
        r.page  = w[PAGE_MSB:PAGE_LSB];
        r.rd    = w[DIR_BIT];
        r.rid   = w[RID_W-1:0];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] en_to_word(class_en_t e);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[SEG_BIT] = e.seg_en;
        w[PG_BIT]  = e.pg_en;
        return w;
    endfunction

endpackage

// File: rtl/fault_cap_regif.sv
module fault_cap_regif
    import fault_cap_pkg::*;
(
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  fault_rec_t        rec_i,
    input  class_en_t         en_i,
    output logic              wr_status_o,
    output logic              wr_mask_o,
    output logic [DATA_W-1:0] rdata_o
);

    reg_sel_e sel;

    always_comb begin
        sel         = reg_sel_e'(reg_addr_i);
        wr_status_o = reg_wr_i && (sel == SEL_STATUS);
        wr_mask_o   = reg_wr_i && (sel == SEL_MASK);
        case (sel)
            SEL_STATUS: rdata_o = rec_to_word(rec_i);
            default:    rdata_o = en_to_word(en_i);
        endcase
    end

endmodule

// File: rtl/fault_cap_mask.sv
module fault_cap_mask
    import fault_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output class_en_t         en_o
);

    class_en_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_i) begin
            en_q.seg_en <= wdata_i[SEG_BIT];
            en_q.pg_en  <= wdata_i[PG_BIT];
        end
    end

    assign en_o = en_q;

    // R6: enables move only on a mask write
    p_mask_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_q));

    // R6: a write loads both class enables
    p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (en_q.seg_en == $past(wdata_i[SEG_BIT])) &&
                 (en_q.pg_en  == $past(wdata_i[PG_BIT])));

endmodule

// File: rtl/fault_cap_record.sv
module fault_cap_record
    import fault_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_valid_i,
    input  logic              flt_kind_i,
    input  logic [PAGE_W-1:0] flt_page_i,
    input  logic              flt_read_i,
    input  logic [RID_W-1:0]  flt_rid_i,
    input  class_en_t         en_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output fault_rec_t        rec_o,
    output logic              irq_o
);

    fault_rec_t  rec_q;
    fault_rec_t  new_rec;
    fault_kind_e kind;
    logic        class_ok;
    logic        take;

    always_comb begin
        kind          = fault_kind_e'(flt_kind_i);
        class_ok      = (kind == KIND_SEG) ? en_i.seg_en : en_i.pg_en;
        take          = flt_valid_i && class_ok && !rec_q.valid && !wr_i;
        new_rec.valid = 1'b1;
        new_rec.seg   = (kind == KIND_SEG);
        new_rec.pg    = (kind == KIND_PAGE);
        new_rec.page  = flt_page_i;
        new_rec.rd    = flt_read_i;
        new_rec.rid   = flt_rid_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (wr_i) begin
            rec_q <= word_to_rec(wdata_i);
        end else if (take) begin
            rec_q <= new_rec;
        end
    end

    assign rec_o = rec_q;
    assign irq_o = rec_q.valid;

    // R2: an enabled fault with nothing pending is recorded next cycle
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (flt_valid_i && !rec_q.valid && !wr_i &&
         ((flt_kind_i == 1'b0) ? en_i.seg_en : en_i.pg_en))
        |=> rec_q.valid && (rec_q.rid == $past(flt_rid_i)) &&
            (rec_q.page == $past(flt_page_i)));

    // R3: interrupt rises after an accepted fault
    p_irq_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (flt_valid_i && !rec_q.valid && !wr_i &&
         ((flt_kind_i == 1'b0) ? en_i.seg_en : en_i.pg_en)) |=> irq_o);

    // R4: a pending record is frozen unless software writes it
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rec_q.valid && !wr_i) |=> $stable(rec_q));

    // R5: a fault of a disabled class leaves the record empty
    p_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (!rec_q.valid && !wr_i &&
         !((flt_kind_i == 1'b0) ? en_i.seg_en : en_i.pg_en)) |=> !irq_o);

    // R7: acknowledging drops the interrupt
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !wdata_i[VALID_BIT]) |=> !irq_o);

    // R8: a status write overrides a concurrent fault
    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (rec_q == word_to_rec($past(wdata_i))));

endmodule

// File: rtl/fault_cap_top.sv
module fault_cap_top
    import fault_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              flt_valid_i,
    input  logic              flt_kind_i,
    input  logic [PAGE_W-1:0] flt_page_i,
    input  logic              flt_read_i,
    input  logic [RID_W-1:0]  flt_rid_i,
    output logic              irq_o
);

    logic       wr_status;
    logic       wr_mask;
    class_en_t  en;
    fault_rec_t rec;

    fault_cap_regif u_regif (
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .rec_i       (rec),
        .en_i        (en),
        .wr_status_o (wr_status),
        .wr_mask_o   (wr_mask),
        .rdata_o     (reg_rdata_o)
    );

    fault_cap_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata_i),
        .en_o    (en)
    );

    fault_cap_record u_record (
        .clk         (clk),
        .rst         (rst),
        .flt_valid_i (flt_valid_i),
        .flt_kind_i  (flt_kind_i),
        .flt_page_i  (flt_page_i),
        .flt_read_i  (flt_read_i),
        .flt_rid_i   (flt_rid_i),
        .en_i        (en),
        .wr_i        (wr_status),
        .wdata_i     (reg_wdata_i),
        .rec_o       (rec),
        .irq_o       (irq_o)
    );

    // R3: interrupt level mirrors the readable valid flag
    p_irq_mirror_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == 1'b0) |-> (irq_o == reg_rdata_o[VALID_BIT]));

    // R9: unstored status bits read as zero
    p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == 1'b0) |-> (reg_rdata_o[PG_BIT-1:PAGE_MSB+1] == '0));

endmodule

// File: tb/fault_cap_top_tb.sv
module fault_cap_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic        reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        flt_valid;
    logic        flt_kind;
    logic [22:0] flt_page;
    logic        flt_read;
    logic [10:0] flt_rid;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fault_cap_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .flt_valid_i (flt_valid),
        .flt_kind_i  (flt_kind),
        .flt_page_i  (flt_page),
        .flt_read_i  (flt_read),
        .flt_rid_i   (flt_rid),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [1:0]  en;    // [1] segment enable, [0] page enable
        logic        kind;  // 0 segment, 1 page
        logic [22:0] page;
        logic        rd;
        logic [10:0] rid;
        logic        hit;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'b11, 1'b0, 23'h000001, 1'b1, 11'h001, 1'b1},
        '{2'b11, 1'b1, 23'h7FFFFF, 1'b0, 11'h7FF, 1'b1},
        '{2'b10, 1'b1, 23'h123456, 1'b1, 11'h0F0, 1'b0},
        '{2'b10, 1'b0, 23'h2AAAAA, 1'b1, 11'h555, 1'b1},
        '{2'b01, 1'b0, 23'h00FF00, 1'b0, 11'h100, 1'b0},
        '{2'b01, 1'b1, 23'h155555, 1'b0, 11'h2AA, 1'b1},
        '{2'b00, 1'b1, 23'h0ABCDE, 1'b1, 11'h3C3, 1'b0}
    };

    function automatic logic [63:0] expect_word(logic kind, logic [22:0] page,
                                                 logic rd, logic [10:0] rid);
        logic [63:0] w;
        w        = '0;
        w[63]    = 1'b1;
        w[62]    = (kind == 1'b0);
        w[61]    = (kind == 1'b1);
        w[34:12] = page;
        w[11]    = rd;
        w[10:0]  = rid;
        return w;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic addr, logic [63:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = addr;
        reg_wdata = data;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 1'b0;
    endtask

    task automatic fault(logic kind, logic [22:0] page, logic rd, logic [10:0] rid);
        @(negedge clk);
        flt_valid = 1'b1;
        flt_kind  = kind;
        flt_page  = page;
        flt_read  = rd;
        flt_rid   = rid;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic read_mask(output logic [63:0] v);
        reg_addr = 1'b1;
        #1;
        v = reg_rdata;
        reg_addr = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] m;
        logic [63:0] first;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        flt_valid = 1'b0; flt_kind = 1'b0; flt_page = '0; flt_read = 1'b0; flt_rid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 status", reg_rdata, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);
        read_mask(m);
        chk("R1 mask", m, 64'h0);

        // R5: fault with all classes disabled after reset
        fault(1'b0, 23'h1, 1'b1, 11'h1);
        chk("R5 reset-masked", reg_rdata, 64'h0);

        // Table of class-enable / fault combinations
        for (int i = 0; i < NV; i++) begin
            reg_write(1'b1, {1'b0, VEC[i].en, 61'h0});
            reg_write(1'b0, 64'h0);
            fault(VEC[i].kind, VEC[i].page, VEC[i].rd, VEC[i].rid);
            if (VEC[i].hit) begin
                // R2 fields and R3 interrupt one cycle after the event
                chk("R2 capture", reg_rdata,
                    expect_word(VEC[i].kind, VEC[i].page, VEC[i].rd, VEC[i].rid));
                chk("R3 irq high", {63'h0, irq}, 64'h1);
            end else begin
                chk("R5 masked status", reg_rdata, 64'h0);
                chk("R5 masked irq", {63'h0, irq}, 64'h0);
            end
        end

        // R6: mask read-back keeps only the two enables
        reg_write(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        read_mask(m);
        chk("R6 mask readback", m, 64'h6000_0000_0000_0000);

        // R4: second fault dropped while first pending
        reg_write(1'b0, 64'h0);
        fault(1'b1, 23'h0F0F0F, 1'b1, 11'h123);
        first = expect_word(1'b1, 23'h0F0F0F, 1'b1, 11'h123);
        chk("R4 first captured", reg_rdata, first);
        fault(1'b0, 23'h7A7A7A, 1'b0, 11'h456);
        chk("R4 second dropped", reg_rdata, first);
        chk("R4 irq still high", {63'h0, irq}, 64'h1);

        // R7: acknowledge by writing back with valid cleared
        reg_write(1'b0, first & ~(64'h1 << 63));
        chk("R7 irq low", {63'h0, irq}, 64'h0);
        chk("R7 fields kept", reg_rdata, first & ~(64'h1 << 63));
        fault(1'b0, 23'h000ABC, 1'b0, 11'h00F);
        chk("R7 rearmed", reg_rdata, expect_word(1'b0, 23'h000ABC, 1'b0, 11'h00F));

        // R8: write and fault in the same cycle, write wins
        reg_write(1'b0, 64'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 64'h0000_0000_0000_0ABC;
        flt_valid = 1'b1; flt_kind = 1'b1; flt_page = 23'h111111; flt_read = 1'b1; flt_rid = 11'h7F0;
        @(negedge clk);
        reg_wr = 1'b0; flt_valid = 1'b0;
        chk("R8 write wins", reg_rdata, 64'h0000_0000_0000_0ABC);
        chk("R8 irq low", {63'h0, irq}, 64'h0);

        // R9: unstored bits read zero
        reg_write(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 unused zero", reg_rdata, 64'hE000_0007_FFFF_FFFF);
        chk("R3 irq from write", {63'h0, irq}, 64'h1);

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 status after reset", reg_rdata, 64'h0);
        chk("R1 irq after reset", {63'h0, irq}, 64'h0);

        done = 1'b1;
        finish_run();
    end

endmodule